// File: doc/BRIEF.md
# Per-Port Lookup Keyset Selector

This block picks, for each ingress frame and for one of four match-table lookups, the key format that the table search must use, and says whether that lookup runs at all. A classifier upstream presents the ingress port number, the lookup index and a few frame flags: the traffic class (non-IP, ARP, IPv4 or IPv6), a multicast flag and a flag for a TCP or UDP payload. One clock later the block returns a keyset code, a lookup-valid flag and a bit that marks the first lookup of each pair.

The behaviour is held in a small register file. Each port and lookup pair has one selection word with a master enable and one selector field per traffic class. Each port also has a lookup-enable mask with one bit per lookup. Both are loaded through a simple write port. Reset loads a default selection word, set by a parameter, into every pair and sets every lookup-enable bit. Some selector settings split one traffic class over two keysets according to the TCP/UDP flag.

Top module: `keyset_selector`

## Requirements
- R1: After reset every port and lookup gives, with lookup-valid set: ARP frames the ARP keyset, IPv4 frames (unicast or multicast) IPv4 TCP/UDP when the TCP/UDP flag is set and IPv4 other when it is clear, IPv6 frames (unicast or multicast) the IP 7-tuple keyset, and non-IP frames MAC/EtherType.
- R2: A request presented in one cycle gives its result on the outputs after the next rising clock edge, with the result-valid flag set. In a cycle after no request, result-valid and lookup-valid are 0 and the keyset code is 0.
- R3: Keyset codes on the output: 0 none, 1 MAC/EtherType, 2 ARP, 3 IPv4 TCP/UDP, 4 IPv4 other, 5 IP 7-tuple, 6 IPv6 standard. Lookup-valid is set only with a nonzero code. A write of the 12-bit selection word to one port and lookup pair changes only that pair. Word layout: bit 11 enable, bit 10 non-IP selector, bits 9:8 IPv4 multicast selector, bits 7:6 IPv4 unicast selector, bits 5:3 IPv6 multicast selector, bits 2:1 IPv6 unicast selector, bit 0 ARP selector. The class input is coded 0 non-IP, 1 ARP, 2 IPv4, 3 IPv6.
- R4: With the enable bit of the pair's selection word clear, the lookup is not valid and the keyset code is 0, whatever the class.
- R5: ARP selector 0 gives MAC/EtherType and 1 gives ARP. The multicast and TCP/UDP flags have no effect on ARP frames.
- R6: The IPv4 selector (the multicast field for multicast frames, the unicast field otherwise) gives: 0 MAC/EtherType; 1 IPv4 TCP/UDP or IPv4 other, chosen by the TCP/UDP flag; 2 IP 7-tuple; 3 no keyset (not valid).
- R7: The IPv6 unicast selector gives: 0 MAC/EtherType, 1 IP 7-tuple, 2 IPv6 standard, 3 IPv4 TCP/UDP or IPv4 other, chosen by the TCP/UDP flag.
- R8: The IPv6 multicast selector codes 0 to 3 act as in R7. Code 4 (kept for a VLAN-based keyset) and codes 5 to 7 give no keyset and a lookup that is not valid.
- R9: The non-IP selector 0 gives MAC/EtherType and 1 gives no keyset. The multicast and TCP/UDP flags have no effect on non-IP frames.
- R10: Bit n of a port's 4-bit lookup-enable mask gates lookup n of that port. A lookup whose bit is clear is not valid and gives code 0. The mask is written per port and does not change the selection words.
- R11: The first-lookup bit is 1 for lookups 0 and 2 and 0 for lookups 1 and 3 on every result, whether or not the lookup is valid.
- R12: A request in the same cycle as a write to its own port and lookup pair uses the old selection word. Requests from the next cycle on use the new one.
- R13: A request for a port number at or above the port count (6 by default, 3-bit port field) gives a lookup that is not valid and code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel_we | input | 1 | Write strobe for one selection word |
| cfg_en_we | input | 1 | Write strobe for one port's lookup-enable mask |
| cfg_port | input | PORT_W (3) | Port addressed by either write |
| cfg_lookup | input | LKP_W (2) | Lookup addressed by a selection-word write |
| cfg_sel_data | input | 12 | Selection word to write (layout in R3) |
| cfg_en_data | input | NUM_LOOKUPS (4) | Lookup-enable mask to write |
| req_valid | input | 1 | A classification request is present |
| req_port | input | PORT_W (3) | Ingress port of the frame |
| req_lookup | input | LKP_W (2) | Lookup index |
| req_class | input | 2 | Traffic class (coding in R3) |
| req_mcast | input | 1 | Frame is multicast |
| req_l4 | input | 1 | Payload is TCP or UDP |
| res_vld | output | 1 | Result of the previous cycle's request |
| res_hit | output | 1 | Lookup runs with a valid keyset |
| res_keyset | output | 3 | Keyset code (R3) |
| res_first | output | 1 | First-lookup bit |

## Verification
A selection-word write and a request can reach the same port and lookup pair in the same clock cycle. In that case the request must read the old word while the write lands at the same edge. The bench drives the write strobe and the request at the same falling edge. The first write moves the ARP selector of one pair from ARP to MAC/EtherType. The result of that cycle must still show the ARP keyset, and a repeat of the request one cycle later must show MAC/EtherType. A second run does the same with a lookup-enable write that clears the bit of the requested lookup.

// File: rtl/ksel_pkg.sv
package ksel_pkg;

    typedef enum logic [1:0] {
        CLS_NONIP = 2'd0,
        CLS_ARP   = 2'd1,
        CLS_IPV4  = 2'd2,
        CLS_IPV6  = 2'd3
    } frm_class_e;

    typedef enum logic [2:0] {
        KS_NONE      = 3'd0,
        KS_MAC_ETYPE = 3'd1,
        KS_ARP       = 3'd2,
        KS_V4_TCPUDP = 3'd3,
        KS_V4_OTHER  = 3'd4,
        KS_SEVEN_TUP = 3'd5,
        KS_V6_STD    = 3'd6
    } keyset_e;

    // Selection word: the first member is the most significant bit.
    typedef struct packed {
        logic       ena;
        logic       nonip_sel;
        logic [1:0] v4mc_sel;
        logic [1:0] v4uc_sel;
        logic [2:0] v6mc_sel;
        logic [1:0] v6uc_sel;
        logic       arp_sel;
    } sel_word_t;

    localparam int SEL_W = $bits(sel_word_t);

    // Default: enabled, ARP keyset for ARP, split IPv4 keysets, 7-tuple for IPv6.
    localparam logic [SEL_W-1:0] SEL_RESET = 12'h94B;

    function automatic keyset_e v4_split(input logic l4);
        return l4 ? KS_V4_TCPUDP : KS_V4_OTHER;
    endfunction

    function automatic keyset_e pick_ipv4(input logic [1:0] code, input logic l4);
        keyset_e ks;
        case (code)
            2'd0:    ks = KS_MAC_ETYPE;
            2'd1:    ks = v4_split(l4);
            2'd2:    ks = KS_SEVEN_TUP;
            default: ks = KS_NONE;
        endcase
        return ks;
    endfunction

    function automatic keyset_e pick_ipv6(input logic [2:0] code, input logic l4);
        keyset_e ks;
        case (code)
            3'd0:    ks = KS_MAC_ETYPE;
            3'd1:    ks = KS_SEVEN_TUP;
            3'd2:    ks = KS_V6_STD;
            3'd3:    ks = v4_split(l4);
            default: ks = KS_NONE;  // 4 is the reserved VLAN keyset
        endcase
        return ks;
    endfunction

    function automatic keyset_e pick_keyset(input sel_word_t w, input frm_class_e cls,
                                            input logic mc, input logic l4);
        keyset_e ks;
        case (cls)
            CLS_ARP:  ks = w.arp_sel ? KS_ARP : KS_MAC_ETYPE;
            CLS_IPV4: ks = pick_ipv4(mc ? w.v4mc_sel : w.v4uc_sel, l4);
            CLS_IPV6: ks = mc ? pick_ipv6(w.v6mc_sel, l4)
                              : pick_ipv6({1'b0, w.v6uc_sel}, l4);
            default:  ks = w.nonip_sel ? KS_NONE : KS_MAC_ETYPE;
        endcase
        return ks;
    endfunction

endpackage

// File: rtl/ksel_cfg_regs.sv
module ksel_cfg_regs
    import ksel_pkg::*;
#(
    parameter int NUM_PORTS   = 6,
    parameter int NUM_LOOKUPS = 4,
    parameter logic [SEL_W-1:0]       SEL_DEFAULT = SEL_RESET,
    parameter logic [NUM_LOOKUPS-1:0] EN_DEFAULT  = '1,
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int LKP_W  = (NUM_LOOKUPS > 1) ? $clog2(NUM_LOOKUPS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sel_we,
    input  logic                   en_we,
    input  logic [PORT_W-1:0]      wr_port,
    input  logic [LKP_W-1:0]       wr_lookup,
    input  sel_word_t              wr_sel,
    input  logic [NUM_LOOKUPS-1:0] wr_en,
    input  logic [PORT_W-1:0]      rd_port,
    input  logic [LKP_W-1:0]       rd_lookup,
    output sel_word_t              rd_sel,
    output logic                   rd_lkp_en,
    output logic                   rd_port_ok
);

    sel_word_t              cell_q [NUM_PORTS][NUM_LOOKUPS];
    logic [NUM_LOOKUPS-1:0] mask_q [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic port_hit;
        assign port_hit = (int'(wr_port) == p);

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[p] <= EN_DEFAULT;
            end else if (en_we && port_hit) begin
                mask_q[p] <= wr_en;
            end
        end

        for (genvar l = 0; l < NUM_LOOKUPS; l++) begin : g_lkp
            always_ff @(posedge clk) begin
                if (rst) begin
                    cell_q[p][l] <= sel_word_t'(SEL_DEFAULT);
                end else if (sel_we && port_hit && (int'(wr_lookup) == l)) begin
                    cell_q[p][l] <= wr_sel;
                end
            end
        end
    end

    always_comb begin
        rd_port_ok = (int'(rd_port) < NUM_PORTS) && (int'(rd_lookup) < NUM_LOOKUPS);
        rd_sel     = '0;
        rd_lkp_en  = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (int'(rd_port) == p) begin
                rd_lkp_en = mask_q[p][rd_lookup];
                for (int l = 0; l < NUM_LOOKUPS; l++) begin
                    if (int'(rd_lookup) == l) rd_sel = cell_q[p][l];
                end
            end
        end
    end

    // A mask write to one port leaves every other port's mask as it was.
    AST_MASK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        (en_we && (wr_port != rd_port)) |=> (rd_lkp_en == $past(rd_lkp_en)) || $changed(rd_port) || $changed(rd_lookup)); // R10

endmodule

// File: rtl/ksel_class_decode.sv
module ksel_class_decode
    import ksel_pkg::*;
(
    input  sel_word_t  sel,
    input  logic       lkp_en,
    input  logic       port_ok,
    input  frm_class_e cls,
    input  logic       mcast,
    input  logic       l4,
    output keyset_e    keyset,
    output logic       hit
);

    keyset_e raw;

    always_comb begin
        raw    = pick_keyset(sel, cls, mcast, l4);
        hit    = port_ok && lkp_en && sel.ena && (raw != KS_NONE);
        keyset = hit ? raw : KS_NONE;
    end

endmodule

// File: rtl/keyset_selector.sv
module keyset_selector
    import ksel_pkg::*;
#(
    parameter int NUM_PORTS   = 6,
    parameter int NUM_LOOKUPS = 4,
    parameter logic [SEL_W-1:0]       SEL_DEFAULT = SEL_RESET,
    parameter logic [NUM_LOOKUPS-1:0] EN_DEFAULT  = '1,
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int LKP_W  = (NUM_LOOKUPS > 1) ? $clog2(NUM_LOOKUPS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_sel_we,
    input  logic                   cfg_en_we,
    input  logic [PORT_W-1:0]      cfg_port,
    input  logic [LKP_W-1:0]       cfg_lookup,
    input  logic [SEL_W-1:0]       cfg_sel_data,
    input  logic [NUM_LOOKUPS-1:0] cfg_en_data,
    input  logic                   req_valid,
    input  logic [PORT_W-1:0]      req_port,
    input  logic [LKP_W-1:0]       req_lookup,
    input  logic [1:0]             req_class,
    input  logic                   req_mcast,
    input  logic                   req_l4,
    output logic                   res_vld,
    output logic                   res_hit,
    output logic [2:0]             res_keyset,
    output logic                   res_first
);

    sel_word_t cur_sel;
    logic      cur_lkp_en;
    logic      cur_port_ok;
    keyset_e   dec_keyset;
    logic      dec_hit;

    ksel_cfg_regs #(
        .NUM_PORTS   (NUM_PORTS),
        .NUM_LOOKUPS (NUM_LOOKUPS),
        .SEL_DEFAULT (SEL_DEFAULT),
        .EN_DEFAULT  (EN_DEFAULT)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .sel_we     (cfg_sel_we),
        .en_we      (cfg_en_we),
        .wr_port    (cfg_port),
        .wr_lookup  (cfg_lookup),
        .wr_sel     (sel_word_t'(cfg_sel_data)),
        .wr_en      (cfg_en_data),
        .rd_port    (req_port),
        .rd_lookup  (req_lookup),
        .rd_sel     (cur_sel),
        .rd_lkp_en  (cur_lkp_en),
        .rd_port_ok (cur_port_ok)
    );

    ksel_class_decode u_dec (
        .sel     (cur_sel),
        .lkp_en  (cur_lkp_en),
        .port_ok (cur_port_ok),
        .cls     (frm_class_e'(req_class)),
        .mcast   (req_mcast),
        .l4      (req_l4),
        .keyset  (dec_keyset),
        .hit     (dec_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld    <= 1'b0;
            res_hit    <= 1'b0;
            res_keyset <= KS_NONE;
            res_first  <= 1'b0;
        end else begin
            res_vld    <= req_valid;
            res_hit    <= req_valid && dec_hit;
            res_keyset <= req_valid ? dec_keyset : KS_NONE;
            res_first  <= req_valid && !req_lookup[0];
        end
    end

    AST_REQ_GIVES_RESULT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_vld); // R2
    AST_IDLE_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!res_vld && !res_hit && (res_keyset == 3'd0))); // R2
    AST_HIT_HAS_KEYSET: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (res_keyset != 3'd0) && (res_keyset <= 3'd6)); // R3
    AST_HIT_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> $past(cur_sel.ena && cur_lkp_en && cur_port_ok)); // R4
    AST_FIRST_FLAG: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> (res_first == !$past(req_lookup[0]))); // R11

endmodule

// File: tb/tb_keyset_selector.sv
module tb_keyset_selector;

    localparam int C_NON = 0, C_ARP = 1, C_V4 = 2, C_V6 = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_sel_we = 1'b0, cfg_en_we = 1'b0;
    logic [2:0] cfg_port = '0;
    logic [1:0] cfg_lookup = '0;
    logic [11:0] cfg_sel_data = '0;
    logic [3:0] cfg_en_data = '0;
    logic       req_valid = 1'b0;
    logic [2:0] req_port = '0;
    logic [1:0] req_lookup = '0;
    logic [1:0] req_class = '0;
    logic       req_mcast = 1'b0, req_l4 = 1'b0;
    logic       res_vld, res_hit, res_first;
    logic [2:0] res_keyset;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    keyset_selector dut (
        .clk(clk), .rst(rst),
        .cfg_sel_we(cfg_sel_we), .cfg_en_we(cfg_en_we),
        .cfg_port(cfg_port), .cfg_lookup(cfg_lookup),
        .cfg_sel_data(cfg_sel_data), .cfg_en_data(cfg_en_data),
        .req_valid(req_valid), .req_port(req_port), .req_lookup(req_lookup),
        .req_class(req_class), .req_mcast(req_mcast), .req_l4(req_l4),
        .res_vld(res_vld), .res_hit(res_hit), .res_keyset(res_keyset),
        .res_first(res_first)
    );

    function automatic logic [11:0] mk(bit ena, bit nonip, bit [1:0] v4mc, bit [1:0] v4uc,
                                       bit [2:0] v6mc, bit [1:0] v6uc, bit arp);
        return {ena, nonip, v4mc, v4uc, v6mc, v6uc, arp};
    endfunction

    task automatic expect_res(string tag, bit vld, bit hit, int ks, bit first);
        n_vec++;
        if (res_vld !== vld || res_hit !== hit || res_keyset !== 3'(ks) || res_first !== first) begin
            n_bad++;
            $display("FAIL %s: got vld=%0b hit=%0b ks=%0d first=%0b, expected vld=%0b hit=%0b ks=%0d first=%0b",
                     tag, res_vld, res_hit, res_keyset, res_first, vld, hit, ks, first);
        end
    endtask

    // Drive at a falling edge, result sampled at the following falling edge.
    task automatic look(string tag, int port, int lkp, int cls, bit mc, bit l4, bit hit, int ks);
        @(negedge clk);
        req_valid = 1'b1; req_port = 3'(port); req_lookup = 2'(lkp);
        req_class = 2'(cls); req_mcast = mc; req_l4 = l4;
        @(negedge clk);
        req_valid = 1'b0;
        expect_res(tag, 1'b1, hit, hit ? ks : 0, (lkp % 2) == 0);
    endtask

    task automatic wr_sel(int port, int lkp, logic [11:0] w);
        @(negedge clk);
        cfg_sel_we = 1'b1; cfg_port = 3'(port); cfg_lookup = 2'(lkp); cfg_sel_data = w;
        @(negedge clk);
        cfg_sel_we = 1'b0;
    endtask

    task automatic wr_en(int port, logic [3:0] m);
        @(negedge clk);
        cfg_en_we = 1'b1; cfg_port = 3'(port); cfg_en_data = m;
        @(negedge clk);
        cfg_en_we = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_res("R2 idle after reset", 1'b0, 1'b0, 0, 1'b0);
        for (int p = 0; p < 6; p++) begin
            for (int l = 0; l < 4; l++) begin
                look("R1 arp",      p, l, C_ARP, 0, 0, 1, 2);
                look("R1 v4mc tcp", p, l, C_V4,  1, 1, 1, 3);
                look("R1 v4uc oth", p, l, C_V4,  0, 0, 1, 4);
                look("R1 v6uc",     p, l, C_V6,  0, 1, 1, 5);
                look("R1 v6mc",     p, l, C_V6,  1, 0, 1, 5);
                look("R1 nonip",    p, l, C_NON, 0, 0, 1, 1);
            end
        end
    endtask

    task automatic t_idle();
        look("R2 one request", 0, 0, C_ARP, 0, 0, 1, 2);
        @(negedge clk);
        expect_res("R2 no request", 1'b0, 1'b0, 0, 1'b0);
    endtask

    task automatic t_arp();
        wr_sel(2, 1, mk(1, 0, 1, 1, 1, 1, 0));
        look("R5 arp sel0",       2, 1, C_ARP, 1, 1, 1, 1);
        wr_sel(2, 1, mk(1, 0, 1, 1, 1, 1, 1));
        look("R5 arp sel1",       2, 1, C_ARP, 0, 0, 1, 2);
        look("R5 arp flags idle", 2, 1, C_ARP, 1, 1, 1, 2);
        look("R3 other pair kept", 2, 0, C_ARP, 0, 0, 1, 2);
    endtask

    task automatic t_ipv4();
        for (int c = 0; c < 4; c++) begin
            wr_sel(1, 0, mk(1, 0, 0, 2'(c), 1, 1, 1));
            look("R6 v4uc tcp", 1, 0, C_V4, 0, 1, c != 3, (c == 0) ? 1 : (c == 1) ? 3 : 5);
            look("R6 v4uc oth", 1, 0, C_V4, 0, 0, c != 3, (c == 0) ? 1 : (c == 1) ? 4 : 5);
            look("R6 v4mc fixed", 1, 0, C_V4, 1, 1, 1, 1);
        end
        wr_sel(1, 0, mk(1, 0, 2, 0, 1, 1, 1));
        look("R6 v4mc 7tup", 1, 0, C_V4, 1, 0, 1, 5);
        wr_sel(1, 0, mk(1, 0, 3, 0, 1, 1, 1));
        look("R6 v4mc none", 1, 0, C_V4, 1, 0, 0, 0);
    endtask

    task automatic t_ipv6();
        for (int c = 0; c < 4; c++) begin
            wr_sel(5, 3, mk(1, 0, 1, 1, 1, 2'(c), 1));
            look("R7 v6uc tcp", 5, 3, C_V6, 0, 1, 1, (c == 0) ? 1 : (c == 1) ? 5 : (c == 2) ? 6 : 3);
            look("R7 v6uc oth", 5, 3, C_V6, 0, 0, 1, (c == 0) ? 1 : (c == 1) ? 5 : (c == 2) ? 6 : 4);
        end
        for (int c = 0; c < 8; c++) begin
            wr_sel(5, 2, mk(1, 0, 1, 1, 3'(c), 1, 1));
            look("R8 v6mc tcp", 5, 2, C_V6, 1, 1, c < 4, (c == 0) ? 1 : (c == 1) ? 5 : (c == 2) ? 6 : 3);
        end
        wr_sel(5, 2, mk(1, 0, 1, 1, 3, 1, 1));
        look("R8 v6mc oth", 5, 2, C_V6, 1, 0, 1, 4);
    endtask

    task automatic t_nonip();
        wr_sel(3, 2, mk(1, 1, 1, 1, 1, 1, 1));
        look("R9 nonip none", 3, 2, C_NON, 0, 0, 0, 0);
        wr_sel(3, 2, mk(1, 0, 1, 1, 1, 1, 1));
        look("R9 nonip flags idle", 3, 2, C_NON, 1, 1, 1, 1);
    endtask

    task automatic t_disable();
        wr_sel(4, 0, mk(0, 0, 1, 1, 1, 1, 1));
        look("R4 off arp",  4, 0, C_ARP, 0, 0, 0, 0);
        look("R4 off v6",   4, 0, C_V6,  1, 1, 0, 0);
        look("R4 off non",  4, 0, C_NON, 0, 0, 0, 0);
    endtask

    task automatic t_lkp_mask();
        wr_en(3, 4'b0101);
        look("R10 lkp0 on",  3, 0, C_ARP, 0, 0, 1, 2);
        look("R10 lkp1 off", 3, 1, C_ARP, 0, 0, 0, 0);
        look("R11 lkp2 on",  3, 2, C_NON, 0, 0, 1, 1);
        look("R11 lkp3 off", 3, 3, C_V4,  0, 1, 0, 0);
        look("R10 other port", 2, 3, C_V4, 0, 1, 1, 3);
        wr_en(3, 4'b1111);
        look("R10 word kept", 3, 1, C_ARP, 0, 0, 1, 2);
        wr_en(3, 4'b0000);
        look("R10 all off", 3, 0, C_ARP, 0, 0, 0, 0);
        wr_en(3, 4'b1111);
    endtask

    task automatic t_collide();
        @(negedge clk);
        cfg_sel_we = 1'b1; cfg_port = 3'd0; cfg_lookup = 2'd2;
        cfg_sel_data = mk(1, 0, 1, 1, 1, 1, 0);
        req_valid = 1'b1; req_port = 3'd0; req_lookup = 2'd2; req_class = 2'(C_ARP);
        req_mcast = 0; req_l4 = 0;
        @(negedge clk);
        cfg_sel_we = 1'b0;
        expect_res("R12 old word used", 1'b1, 1'b1, 2, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        expect_res("R12 new word next", 1'b1, 1'b1, 1, 1'b1);
        @(negedge clk);
        cfg_en_we = 1'b1; cfg_port = 3'd0; cfg_en_data = 4'b1011;
        req_valid = 1'b1; req_port = 3'd0; req_lookup = 2'd2;
        @(negedge clk);
        cfg_en_we = 1'b0;
        expect_res("R12 old mask used", 1'b1, 1'b1, 1, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        expect_res("R12 new mask next", 1'b1, 1'b0, 0, 1'b1);
    endtask

    task automatic t_range();
        look("R13 port6", 6, 0, C_ARP, 0, 0, 0, 0);
        look("R13 port7", 7, 1, C_V4,  0, 1, 0, 0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_arp();
        t_ipv4();
        t_ipv6();
        t_nonip();
        t_disable();
        t_lkp_mask();
        t_collide();
        t_range();
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule